// File: doc/BRIEF.md
# Text RAM to ANSI terminal bridge

The block presents a 2048-byte text memory on a byte-wide processor bus. Every write is stored in the memory. A write that lands in the 80 by 24 visible cell area is also converted into a short run of ANSI terminal bytes on a byte-stream output. That run can switch reverse video on or off, can move the cursor, and always carries the translated character. Reads return the stored byte. A terminal on the far end of a serial link therefore mirrors the screen without any raster logic.

The board decodes a single aligned 2048-byte window and honours accesses only while the external bank select is zero. To keep the byte stream short, the bridge remembers the current attribute and the last cell written. It omits the attribute change when the attribute is unchanged. It omits the cursor move when the new cell directly follows the previous one on the same row. While a byte run is still draining, the bridge drops its bus-ready output, so the processor waits and no write is lost or reordered.

Top module: `ansi_text_bridge`

## Requirements
- R1: The block claims only addresses whose bits above bit 10 equal those of BASE_ADDR (an aligned 2048-byte window). A write outside the window changes nothing and emits nothing. A read outside the window returns 0xFF.
- R2: An access is honoured only when bank_i is 0. With any other bank value a write changes nothing and emits nothing, and a read returns 0xFF.
- R3: An accepted read loads bus_rdata_o on the accepting clock edge with the byte last written at that offset, for every offset from 0 to 2047. bus_rdata_o holds that value until the next accepted read. It is 0xFF after reset.
- R4: A write to offsets 1920 to 2047 is stored but produces no stream output.
- R5: Bit 7 of a written byte selects reverse video. An attribute flag is cleared at reset. When bit 7 is 1 and the flag is clear, the run begins with 1B 5B 30 37 6D (ESC [ 0 7 m) and the flag is set. When bit 7 is 0 and the flag is set, the run begins with 1B 5B 30 30 6D (ESC [ 0 0 m) and the flag is cleared. When bit 7 equals the flag, no attribute bytes are sent.
- R6: The character byte is the written byte's low 7 bits. Values 0x00 to 0x1F are sent as 0x4F ('O') and 0x7F is sent as 0x58 ('X'). Stream bytes never have bit 7 set.
- R7: For a visible offset, column = offset mod 80 + 1 and row = offset div 80 + 1. If the row equals the stored row and the column equals the stored column + 1, only the character is sent. Otherwise the run carries 1B 5B, the row in decimal ASCII, 3B, the column in decimal ASCII, 48 (ESC [ r ; c H), and then the character. Numbers 1 to 9 take one digit and 10 to 80 take two digits.
- R8: The stored row and column are 0 after reset, so the first visible write always carries a full cursor move. After each visible write they hold the cell just written.
- R9: Within one run the order is the attribute sequence, then the cursor move, then the character.
- R10: bus_ready_o is 1 in reset and whenever no run is pending. An accepted visible write drops it on the next cycle, and it stays 0 until the last byte of the run is accepted. An access is accepted only in a cycle with bus_ready_o high. Runs come out in write order.
- R11: tx_valid_o and tx_data_o stay stable while tx_valid_o is 1 and tx_ready_i is 0. A byte is transferred in a cycle where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write request, held until accepted |
| bus_rd_i | input | 1 | Read request, held until accepted (write wins if both) |
| bank_i | input | BANK_W | External bank select; accesses honoured only at 0 |
| bus_rdata_o | output | 8 | Registered read data |
| bus_ready_o | output | 1 | Access accepted in a cycle where this is high |
| tx_data_o | output | 8 | Terminal stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |

## Verification
On every cycle the assertions check that a stalled stream byte holds, that the stream stays within ESC and printable ASCII, and that missed, off-bank and hidden-area writes stay silent. They also check that a visible write raises busy on the next cycle and that rejected reads return 0xFF. Only the bench scenarios can show that the byte runs carry the right content: the attribute transitions, the cursor omission for consecutive cells, the one- and two-digit numbers, the row wrap, and the ordering across back-to-back writes. The bench compares these runs with a model of the requirements, under random sink back-pressure and random addresses.

// File: rtl/ansi_bridge_pkg.sv
`timescale 1ns/1ps
package ansi_bridge_pkg;
  localparam int unsigned NUM_W = 7;  // row/col field; formatter handles up to 99

  typedef enum logic [3:0] {
    ST_IDLE, ST_A_ESC, ST_A_LB, ST_A_Z, ST_A_D, ST_A_M,
    ST_P_ESC, ST_P_LB, ST_P_RT, ST_P_RO, ST_P_SC, ST_P_CT, ST_P_CO, ST_P_H,
    ST_CHR
  } seq_st_e;

  localparam logic [7:0] ASC_ESC = 8'h1B;
  localparam logic [7:0] ASC_LB  = 8'h5B;
  localparam logic [7:0] ASC_0   = 8'h30;
  localparam logic [7:0] ASC_7   = 8'h37;
  localparam logic [7:0] ASC_M   = 8'h6D;
  localparam logic [7:0] ASC_SC  = 8'h3B;
  localparam logic [7:0] ASC_H   = 8'h48;
  localparam logic [7:0] ASC_O   = 8'h4F;
  localparam logic [7:0] ASC_X   = 8'h58;

  typedef struct packed {
    logic             attr_chg;
    logic             attr_on;
    logic             pos_req;
    logic [NUM_W-1:0] row;
    logic [NUM_W-1:0] col;
    logic [7:0]       chr;
  } seq_cmd_t;
endpackage

// File: rtl/ansi_cell_map.sv
`timescale 1ns/1ps
module ansi_cell_map
  import ansi_bridge_pkg::*;
#(
  parameter int unsigned OFF_W = 11,
  parameter int unsigned COLS  = 80,
  parameter int unsigned ROWS  = 24
) (
  input  logic [OFF_W-1:0] off_i,
  output logic             visible_o,
  output logic [NUM_W-1:0] row_o,
  output logic [NUM_W-1:0] col_o
);
  localparam int unsigned VIS = COLS * ROWS;

  int unsigned o;
  always_comb begin
    o         = 32'(off_i);
    visible_o = o < VIS;
    row_o     = NUM_W'(o / COLS + 1);
    col_o     = NUM_W'(o % COLS + 1);
  end
endmodule

// File: rtl/ansi_char_xlat.sv
`timescale 1ns/1ps
module ansi_char_xlat
  import ansi_bridge_pkg::*;
(
  input  logic [7:0] data_i,
  output logic [7:0] chr_o
);
  logic [6:0] lo;
  always_comb begin
    lo = data_i[6:0];
    if (lo < 7'h20)       chr_o = ASC_O;
    else if (lo == 7'h7F) chr_o = ASC_X;
    else                  chr_o = {1'b0, lo};
  end
endmodule

// File: rtl/ansi_dec_digits.sv
`timescale 1ns/1ps
module ansi_dec_digits #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] val_i,
  output logic [7:0]   tens_o,
  output logic [7:0]   ones_o,
  output logic         two_o
);
  logic [W-1:0] t, u;
  always_comb begin
    t      = val_i / W'(10);
    u      = val_i % W'(10);
    tens_o = 8'h30 + 8'(t);
    ones_o = 8'h30 + 8'(u);
    two_o  = val_i >= W'(10);
  end
endmodule

// File: rtl/ansi_seq_fsm.sv
`timescale 1ns/1ps
module ansi_seq_fsm
  import ansi_bridge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  seq_cmd_t   cmd_i,
  output logic       busy_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i
);
  seq_st_e  st_q, st_nxt, st_first;
  seq_cmd_t cmd_q;

  logic [NUM_W-1:0] num [2];
  logic [7:0]       tens [2];
  logic [7:0]       ones [2];
  logic             two [2];

  assign num[0] = cmd_q.row;
  assign num[1] = cmd_q.col;

  for (genvar g = 0; g < 2; g++) begin : g_dig
    ansi_dec_digits #(.W(NUM_W)) u_dig (
      .val_i  (num[g]),
      .tens_o (tens[g]),
      .ones_o (ones[g]),
      .two_o  (two[g])
    );
  end

  always_comb begin
    if (cmd_i.attr_chg)     st_first = ST_A_ESC;
    else if (cmd_i.pos_req) st_first = ST_P_ESC;
    else                    st_first = ST_CHR;
  end

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:  st_nxt = ST_IDLE;
      ST_A_ESC: st_nxt = ST_A_LB;
      ST_A_LB:  st_nxt = ST_A_Z;
      ST_A_Z:   st_nxt = ST_A_D;
      ST_A_D:   st_nxt = ST_A_M;
      ST_A_M:   st_nxt = cmd_q.pos_req ? ST_P_ESC : ST_CHR;
      ST_P_ESC: st_nxt = ST_P_LB;
      ST_P_LB:  st_nxt = two[0] ? ST_P_RT : ST_P_RO;
      ST_P_RT:  st_nxt = ST_P_RO;
      ST_P_RO:  st_nxt = ST_P_SC;
      ST_P_SC:  st_nxt = two[1] ? ST_P_CT : ST_P_CO;
      ST_P_CT:  st_nxt = ST_P_CO;
      ST_P_CO:  st_nxt = ST_P_H;
      ST_P_H:   st_nxt = ST_CHR;
      ST_CHR:   st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_A_ESC, ST_P_ESC: tx_data_o = ASC_ESC;
      ST_A_LB,  ST_P_LB:  tx_data_o = ASC_LB;
      ST_A_Z:             tx_data_o = ASC_0;
      ST_A_D:             tx_data_o = cmd_q.attr_on ? ASC_7 : ASC_0;
      ST_A_M:             tx_data_o = ASC_M;
      ST_P_RT:            tx_data_o = tens[0];
      ST_P_RO:            tx_data_o = ones[0];
      ST_P_SC:            tx_data_o = ASC_SC;
      ST_P_CT:            tx_data_o = tens[1];
      ST_P_CO:            tx_data_o = ones[1];
      ST_P_H:             tx_data_o = ASC_H;
      ST_CHR:             tx_data_o = cmd_q.chr;
      default:            tx_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
    end else if (start_i) begin
      st_q  <= st_first;
      cmd_q <= cmd_i;
    end else if (st_q != ST_IDLE && tx_ready_i) begin
      st_q  <= st_nxt;
    end
  end

  assign busy_o     = st_q != ST_IDLE;
  assign tx_valid_o = st_q != ST_IDLE;
endmodule

// File: rtl/ansi_text_bridge.sv
`timescale 1ns/1ps
module ansi_text_bridge
  import ansi_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MEM_BYTES = 2048,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4800,
  parameter int unsigned COLS      = 80,
  parameter int unsigned ROWS      = 24,
  parameter int unsigned BANK_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_ready_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  localparam int unsigned OFF_W = $clog2(MEM_BYTES);

  logic [OFF_W-1:0] off;
  logic hit, bank_ok, wr_go, rd_go, start, busy, visible;
  logic [NUM_W-1:0] row, col, cur_row_q, cur_col_q;
  logic [7:0] chr, rdata_q;
  logic attr_q;
  seq_cmd_t cmd;

  logic [7:0] mem [MEM_BYTES];

  assign off     = bus_addr_i[OFF_W-1:0];
  assign hit     = bus_addr_i[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W];
  assign bank_ok = bank_i == '0;
  assign bus_ready_o = !busy;
  assign wr_go   = bus_wr_i && bus_ready_o && hit && bank_ok;
  assign rd_go   = bus_rd_i && !bus_wr_i && bus_ready_o;
  assign start   = wr_go && visible;

  always_ff @(posedge clk_i) begin
    if (wr_go) mem[off] <= bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= 8'hFF;
    else if (rd_go) rdata_q <= (hit && bank_ok) ? mem[off] : 8'hFF;
  end
  assign bus_rdata_o = rdata_q;

  ansi_cell_map #(.OFF_W(OFF_W), .COLS(COLS), .ROWS(ROWS)) u_map (
    .off_i     (off),
    .visible_o (visible),
    .row_o     (row),
    .col_o     (col)
  );

  ansi_char_xlat u_xlat (
    .data_i (bus_wdata_i),
    .chr_o  (chr)
  );

  always_comb begin
    cmd.attr_chg = bus_wdata_i[7] != attr_q;
    cmd.attr_on  = bus_wdata_i[7];
    cmd.pos_req  = !((row == cur_row_q) && (col == cur_col_q + NUM_W'(1)));
    cmd.row      = row;
    cmd.col      = col;
    cmd.chr      = chr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q    <= 1'b0;
      cur_row_q <= '0;
      cur_col_q <= '0;
    end else if (start) begin
      attr_q    <= bus_wdata_i[7];
      cur_row_q <= row;
      cur_col_q <= col;
    end
  end

  ansi_seq_fsm u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cmd_i      (cmd),
    .busy_o     (busy),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i)
  );
endmodule

// File: rtl/ansi_text_bridge_chk.sv
`timescale 1ns/1ps
module ansi_text_bridge_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MEM_BYTES = 2048,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4800,
  parameter int unsigned COLS      = 80,
  parameter int unsigned ROWS      = 24,
  parameter int unsigned BANK_W    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [7:0]        bus_rdata_o,
  input logic              bus_ready_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i
);
  localparam int unsigned OFF_W = $clog2(MEM_BYTES);
  localparam int unsigned VIS   = COLS * ROWS;

  logic in_win, on_bank, hidden;
  assign in_win  = bus_addr_i[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W];
  assign on_bank = bank_i == '0;
  assign hidden  = 32'(bus_addr_i[OFF_W-1:0]) >= VIS;

  a_r11_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r6_tx_charset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_data_o == 8'h1B) || (tx_data_o >= 8'h20 && tx_data_o <= 8'h7E));

  a_r1_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o && bus_wr_i && !in_win |=> !tx_valid_o);

  a_r2_bank_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o && bus_wr_i && !on_bank |=> !tx_valid_o);

  a_r4_hidden_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o && bus_wr_i && in_win && on_bank && hidden |=> !tx_valid_o);

  a_r10_visible_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o && bus_wr_i && in_win && on_bank && !hidden |=> tx_valid_o && !bus_ready_o);

  a_r1_reject_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o && bus_rd_i && !bus_wr_i && (!in_win || !on_bank) |=> bus_rdata_o == 8'hFF);
endmodule

bind ansi_text_bridge ansi_text_bridge_chk #(
  .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .BASE_ADDR(BASE_ADDR),
  .COLS(COLS), .ROWS(ROWS), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/ansi_text_bridge_tb.sv
`timescale 1ns/1ps
module ansi_text_bridge_tb;
  localparam int unsigned BASE = 32'h4800;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [3:0]  bank_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        bus_ready_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;

  ansi_text_bridge u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  int stall_cnt = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] mmem [2048];
  bit         mval [2048];
  bit m_attr = 0;
  int m_row = 0, m_col = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] xlat(logic [7:0] d);
    if (d[6:0] < 7'h20) return 8'h4F;
    if (d[6:0] == 7'h7F) return 8'h58;
    return {1'b0, d[6:0]};
  endfunction

  function automatic void push_num(int v);
    if (v >= 10) exp_q.push_back(8'(8'h30 + v / 10));
    exp_q.push_back(8'(8'h30 + v % 10));
  endfunction

  function automatic void m_write(int unsigned a, logic [7:0] d, int unsigned bk);
    int unsigned off;
    int r, c;
    if ((a >> 11) != (BASE >> 11) || bk != 0) return;
    off = a & 2047;
    mmem[off] = d;
    mval[off] = 1;
    if (off >= 1920) return;
    r = off / 80 + 1;
    c = off % 80 + 1;
    if (d[7] != m_attr) begin
      exp_q.push_back(8'h1B); exp_q.push_back(8'h5B); exp_q.push_back(8'h30);
      exp_q.push_back(d[7] ? 8'h37 : 8'h30); exp_q.push_back(8'h6D);
      m_attr = d[7];
    end
    if (!(r == m_row && c == m_col + 1)) begin
      exp_q.push_back(8'h1B); exp_q.push_back(8'h5B);
      push_num(r); exp_q.push_back(8'h3B); push_num(c); exp_q.push_back(8'h48);
    end
    exp_q.push_back(xlat(d));
    m_row = r;
    m_col = c;
  endfunction

  task automatic bus_write(int unsigned a, logic [7:0] d, int unsigned bk);
    @(negedge clk_i);
    bus_addr_i = 16'(a); bus_wdata_i = d; bank_i = 4'(bk); bus_wr_i = 1'b1;
    while (!bus_ready_o) begin
      stall_cnt++;
      @(negedge clk_i);
    end
    @(posedge clk_i);
    m_write(a, d, bk);
    #1 bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(int unsigned a, int unsigned bk, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = 16'(a); bank_i = 4'(bk); bus_rd_i = 1'b1;
    while (!bus_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 bus_rd_i = 1'b0;
    @(negedge clk_i);
    d = bus_rdata_o;
  endtask

  task automatic drain_check(string tag);
    bit ok;
    int first;
    repeat (2) @(negedge clk_i);
    while (!(bus_ready_o && !tx_valid_o)) @(negedge clk_i);
    @(negedge clk_i);
    ok = rx_q.size() == exp_q.size();
    first = -1;
    for (int i = 0; i < rx_q.size() && i < exp_q.size(); i++)
      if (rx_q[i] !== exp_q[i] && first < 0) first = i;
    if (first >= 0) begin
      ok = 0;
      chk(ok, {tag, " stream byte"}, int'(rx_q[first]), int'(exp_q[first]));
    end else begin
      chk(ok, {tag, " stream length"}, rx_q.size(), exp_q.size());
    end
    rx_q.delete();
    exp_q.delete();
  endtask

  // stream sink with random back-pressure
  initial begin
    forever begin
      bit r;
      @(negedge clk_i);
      r = ($urandom % 4) != 0;
      tx_ready_i = r;
      if (tx_valid_o && r) rx_q.push_back(tx_data_o);
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int unsigned seed;
    int unsigned last_off;
    seed = $urandom(32'h1234_5678);
    repeat (4) @(negedge clk_i);
    // R10 reset state
    chk(bus_ready_o == 1'b1, "R10 reset ready", bus_ready_o, 1);
    chk(tx_valid_o == 1'b0, "R11 reset valid", tx_valid_o, 0);
    chk(bus_rdata_o == 8'hFF, "R3 reset rdata", bus_rdata_o, 8'hFF);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    bus_write(BASE + 0, 8'h41, 0);    drain_check("R8 first write full move");
    bus_write(BASE + 1, 8'h42, 0);    drain_check("R7 consecutive char only");
    bus_write(BASE + 5, 8'hC1, 0);    drain_check("R5 R9 reverse on then move");
    bus_write(BASE + 6, 8'h81, 0);    drain_check("R6 control char, attr kept");
    bus_write(BASE + 7, 8'h7F, 0);    drain_check("R5 reverse off, R6 block char");
    bus_write(BASE + 1919, 8'h5A, 0); drain_check("R7 two-digit row and col");
    bus_write(BASE + 79, 8'h31, 0);   drain_check("R7 col 80");
    bus_write(BASE + 80, 8'h32, 0);   drain_check("R7 row wrap needs move");
    bus_write(BASE + 809, 8'h33, 0);  drain_check("R7 row 11 col 10");

    bus_write(BASE + 1920, 8'h55, 0); drain_check("R4 hidden write silent");
    bus_read(BASE + 1920, 0, rd);
    chk(rd == 8'h55, "R4 hidden stored", rd, 8'h55);
    bus_write(BASE + 2047, 8'hAA, 0); drain_check("R4 top offset silent");
    bus_read(BASE + 2047, 0, rd);
    chk(rd == 8'hAA, "R3 top offset read", rd, 8'hAA);

    bus_write(BASE + 10, 8'h44, 1);   drain_check("R2 off-bank write silent");
    bus_read(BASE + 1, 0, rd);
    chk(rd == 8'h42, "R3 read stored", rd, 8'h42);
    bus_write(BASE + 1, 8'h77, 3);
    bus_read(BASE + 1, 0, rd);
    chk(rd == 8'h42, "R2 off-bank write no effect", rd, 8'h42);
    bus_read(BASE + 1, 2, rd);
    chk(rd == 8'hFF, "R2 off-bank read", rd, 8'hFF);

    bus_write(BASE - 1, 8'h61, 0);
    bus_write(BASE + 2048, 8'h62, 0);
    drain_check("R1 outside window silent");
    bus_read(BASE + 2048, 0, rd);
    chk(rd == 8'hFF, "R1 outside read", rd, 8'hFF);
    bus_read(BASE - 1, 0, rd);
    chk(rd == 8'hFF, "R1 below window read", rd, 8'hFF);
    bus_read(BASE + 0, 0, rd);
    chk(rd == 8'h41, "R1 window base read", rd, 8'h41);

    // R10 back-to-back writes stall and keep order
    stall_cnt = 0;
    bus_write(BASE + 300, 8'hE5, 0);
    bus_write(BASE + 301, 8'h66, 0);
    bus_write(BASE + 302, 8'h67, 0);
    chk(stall_cnt > 0, "R10 bus stalled while busy", stall_cnt, 1);
    drain_check("R10 R9 back-to-back order");

    // random mix
    last_off = 0;
    for (int n = 0; n < 400; n++) begin
      int unsigned kind, a, off, bk;
      kind = $urandom % 10;
      bk = (($urandom % 10) == 0) ? 1 + $urandom % 15 : 0;
      if (kind < 4) off = (last_off + 1) % 1920;
      else          off = $urandom % 2048;
      a = BASE + off;
      if (kind == 9) a = (BASE + 2048 + $urandom % 4096) & 16'hFFFF;
      if (kind == 8 && mval[off]) begin
        bus_read(a, 0, rd);
        chk(rd == mmem[off], "R3 random read", rd, mmem[off]);
      end else begin
        bus_write(a, 8'($urandom), bk);
        if (bk == 0 && kind != 9) last_off = off;
      end
    end
    drain_check("R7 R8 R5 random stream");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule